// File: doc/BRIEF.md
# Load/Store Memory Unit

This block is the memory side of a small out-of-order core with a 16-bit datapath. It holds two load slots and two store slots. An instruction enters a slot through an issue port, with its base operand, its store data (for stores), a 7-bit signed offset and a destination tag (for loads). Operands that are not yet available arrive later over a snooped result bus, matched by tag. Once a slot has its operands, it spends one cycle forming the effective address. It then competes for a single memory port.

Loads put the word they read back on the outgoing result channel, tagged with their destination. Stores write their data word and retire silently. Slot age is tracked so that the memory port always serves the oldest eligible slot. A load never reads ahead of an older store that is unresolved or that targets the same word.

The issue and result channels are valid/ready. The issue side stalls with `iss_ready` low when no slot of the requested kind is free. The result side holds its word until the consumer takes it. The memory port never stalls: the write happens at the clock edge that ends the request cycle, and read data returns combinationally in the request cycle.

Top module: `lsu_mem_unit`

## Requirements
- R1: `iss_ready` is high exactly when a slot of the kind chosen by `iss_store` (0 = load, 1 = store) is free. A transfer happens at a clock edge where `iss_valid` and `iss_ready` are both high.
- R2: The memory address is the base operand plus the 7-bit offset sign-extended (range -64..63), taken modulo 2^16.
- R3: A load waits only for its base operand; a store waits for base and data. A pending operand is filled from `cdb_data` when `cdb_valid` is high and `cdb_tag` matches, including in the very cycle the instruction is transferred in.
- R4: With operands ready at transfer edge k, the memory request is present in the cycle that ends at edge k+2. When an operand arrives on the result bus at edge c, the request is present in the cycle ending at edge c+2, absent port contention.
- R5: A load presents the word read (`mem_we` = 0) on `res_data` with its tag on `res_tag`. While `res_valid` is high and `res_ready` low, `res_valid`, `res_tag` and `res_data` hold. The slot frees on the transfer.
- R6: A store drives `mem_valid` with `mem_we` = 1, its address and its data for one cycle, then frees its slot and produces no result transfer.
- R7: A load makes no memory request while an older store is still waiting for operands, or holds the same address and has not written.
- R8: When several slots may use the memory port in one cycle, the oldest by transfer order is served and the others wait.
- R9: After reset no slot is occupied, `iss_ready` is high, and `res_valid` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue channel valid |
| iss_ready | output | 1 | Issue channel ready (slot of requested kind free) |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_dst | input | 4 | Destination tag of a load |
| iss_base_tag | input | 4 | Tag producing the base operand |
| iss_base_val | input | 16 | Base operand value |
| iss_base_rdy | input | 1 | Base operand value is valid |
| iss_data_tag | input | 4 | Tag producing the store data |
| iss_data_val | input | 16 | Store data value |
| iss_data_rdy | input | 1 | Store data value is valid |
| iss_off | input | 7 | Signed address offset |
| cdb_valid | input | 1 | Snooped result bus valid |
| cdb_tag | input | 4 | Snooped result bus tag |
| cdb_data | input | 16 | Snooped result bus value |
| res_valid | output | 1 | Load result valid |
| res_ready | input | 1 | Load result accepted |
| res_tag | output | 4 | Load result tag |
| res_data | output | 16 | Load result word |
| mem_valid | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, same cycle |

## Verification
The hardest situation to reach is the one where a load is ready but must stay off the memory port because an older store is still unresolved. The same applies when several slots become eligible in the same cycle and the port has to pick by age. The stimulus reaches both by issuing a store whose data is not yet produced, followed by loads to the same and to a different word. The pending tag is then released with a single result-bus broadcast, which lets the store and both loads compete in consecutive cycles. A second case parks an older load and a younger store on the same base tag, so one broadcast makes both eligible at once.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  parameter int XW = 16;  // data and address width
  parameter int TW = 4;   // tag width
  parameter int IW = 7;   // offset width

  typedef enum logic [1:0] {ST_FREE, ST_OPND, ST_MEM, ST_RES} slot_st_e;

  typedef struct packed {
    logic [TW-1:0] dst;
    logic [TW-1:0] b_tag;
    logic [XW-1:0] b_val;
    logic          b_rdy;
    logic [TW-1:0] d_tag;
    logic [XW-1:0] d_val;
    logic          d_rdy;
    logic [IW-1:0] off;
  } slot_ent_t;
endpackage

// File: rtl/lsu_slot.sv
module lsu_slot import lsu_pkg::*; #(
  parameter bit IS_ST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  slot_ent_t     ent_i,
  input  logic          cdb_v,
  input  logic [TW-1:0] cdb_tag,
  input  logic [XW-1:0] cdb_val,
  input  logic          mem_gnt,
  input  logic [XW-1:0] mem_rdata,
  input  logic          res_take,
  output logic          busy,
  output logic          at_mem,
  output logic          at_res,
  output logic [XW-1:0] addr,
  output logic [XW-1:0] wdata,
  output logic [TW-1:0] dst,
  output logic [XW-1:0] rdata
);
  slot_st_e      st;
  slot_ent_t     e;
  logic [XW-1:0] ea, rd;
  logic          ops_ok;

  function automatic slot_ent_t snoop(slot_ent_t x, logic v, logic [TW-1:0] t, logic [XW-1:0] d);
    slot_ent_t y = x;
    if (v && !y.b_rdy && y.b_tag == t) begin y.b_val = d; y.b_rdy = 1'b1; end
    if (v && !y.d_rdy && y.d_tag == t) begin y.d_val = d; y.d_rdy = 1'b1; end
    return y;
  endfunction

  assign ops_ok = e.b_rdy && (!IS_ST || e.d_rdy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_FREE;
      e  <= '0;
      ea <= '0;
      rd <= '0;
    end else begin
      case (st)
        ST_FREE: if (alloc) begin
          e  <= snoop(ent_i, cdb_v, cdb_tag, cdb_val);
          st <= ST_OPND;
        end
        ST_OPND: if (ops_ok) begin
          ea <= e.b_val + {{(XW-IW){e.off[IW-1]}}, e.off};
          st <= ST_MEM;
        end else begin
          e <= snoop(e, cdb_v, cdb_tag, cdb_val);
        end
        ST_MEM: if (mem_gnt) begin
          if (IS_ST) st <= ST_FREE;
          else begin
            rd <= mem_rdata;
            st <= ST_RES;
          end
        end
        default: if (res_take) st <= ST_FREE;
      endcase
    end
  end

  assign busy   = (st != ST_FREE);
  assign at_mem = (st == ST_MEM);
  assign at_res = (st == ST_RES);
  assign addr   = ea;
  assign wdata  = e.d_val;
  assign dst    = e.dst;
  assign rdata  = rd;

  // R3: address phase only entered with the required operands present
  a_r3_ops_before_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEM && $past(st) == ST_OPND) |-> ($past(e.b_rdy) && (!IS_ST || $past(e.d_rdy))));

  // R4: a result appears only after a granted memory access
  a_r4_res_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RES && $past(st) != ST_RES) |-> ($past(st) == ST_MEM && $past(mem_gnt)));
endmodule

// File: rtl/lsu_age_arb.sv
module lsu_age_arb #(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        alloc,
  input  logic [N-1:0]        busy,
  input  logic [N-1:0]        mem_req,
  input  logic [N-1:0]        res_req,
  input  logic                res_fire,
  output logic [N-1:0]        mem_gnt,
  output logic [N-1:0]        res_oh,
  output logic [N-1:0][N-1:0] older   // older[j][i]: slot j entered before slot i
);
  logic         hold;
  logic [N-1:0] hold_oh;

  function automatic logic [N-1:0] oldest(logic [N-1:0] req, logic [N-1:0][N-1:0] o);
    logic [N-1:0] oh;
    for (int i = 0; i < N; i++) begin
      oh[i] = req[i];
      for (int j = 0; j < N; j++)
        if (req[j] && o[j][i]) oh[i] = 1'b0;
    end
    return oh;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older   <= '0;
      hold    <= 1'b0;
      hold_oh <= '0;
    end else begin
      for (int n = 0; n < N; n++) begin
        if (alloc[n]) begin
          for (int j = 0; j < N; j++) begin
            older[j][n] <= busy[j];
            older[n][j] <= 1'b0;
          end
        end
      end
      hold    <= (|res_req) && !res_fire;
      hold_oh <= res_oh;
    end
  end

  assign mem_gnt = oldest(mem_req, older);
  assign res_oh  = hold ? hold_oh : oldest(res_req, older);

  // R8: the shared port serves at most one slot
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_gnt));

  // R5: a single result source at a time, drawn from waiting slots
  a_r5_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_oh) && ((res_oh & ~res_req) == '0));
endmodule

// File: rtl/lsu_mem_unit.sv
module lsu_mem_unit import lsu_pkg::*; #(
  parameter int NUM_LD = 2,
  parameter int NUM_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic          iss_store,
  input  logic [TW-1:0] iss_dst,
  input  logic [TW-1:0] iss_base_tag,
  input  logic [XW-1:0] iss_base_val,
  input  logic          iss_base_rdy,
  input  logic [TW-1:0] iss_data_tag,
  input  logic [XW-1:0] iss_data_val,
  input  logic          iss_data_rdy,
  input  logic [IW-1:0] iss_off,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [XW-1:0] cdb_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [TW-1:0] res_tag,
  output logic [XW-1:0] res_data,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  input  logic [XW-1:0] mem_rdata
);
  localparam int N = NUM_LD + NUM_ST;

  slot_ent_t           ent;
  logic [N-1:0]        busy, at_mem, at_res, free_kind, alloc, blk, mem_req, mem_gnt, res_oh, res_take;
  logic [N-1:0][N-1:0] older;
  logic [XW-1:0]       addr_a [N];
  logic [XW-1:0]       wdat_a [N];
  logic [XW-1:0]       rdat_a [N];
  logic [TW-1:0]       dst_a  [N];

  always_comb begin
    ent.dst   = iss_dst;
    ent.b_tag = iss_base_tag;
    ent.b_val = iss_base_val;
    ent.b_rdy = iss_base_rdy;
    ent.d_tag = iss_data_tag;
    ent.d_val = iss_data_val;
    ent.d_rdy = iss_data_rdy;
    ent.off   = iss_off;
    for (int i = 0; i < N; i++)
      free_kind[i] = !busy[i] && ((i >= NUM_LD) == iss_store);
  end

  assign iss_ready = |free_kind;
  assign alloc     = iss_valid ? (free_kind & (~free_kind + N'(1))) : '0;

  for (genvar g = 0; g < N; g++) begin : g_slot
    lsu_slot #(.IS_ST(g >= NUM_LD)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc[g]),
      .ent_i    (ent),
      .cdb_v    (cdb_valid),
      .cdb_tag  (cdb_tag),
      .cdb_val  (cdb_data),
      .mem_gnt  (mem_gnt[g]),
      .mem_rdata(mem_rdata),
      .res_take (res_take[g]),
      .busy     (busy[g]),
      .at_mem   (at_mem[g]),
      .at_res   (at_res[g]),
      .addr     (addr_a[g]),
      .wdata    (wdat_a[g]),
      .dst      (dst_a[g]),
      .rdata    (rdat_a[g])
    );
  end

  // a load stays off the port behind an older store that is unresolved or aliases it
  always_comb begin
    blk = '0;
    for (int i = 0; i < NUM_LD; i++)
      for (int j = NUM_LD; j < N; j++)
        if (older[j][i] && busy[j] && (!at_mem[j] || addr_a[j] == addr_a[i]))
          blk[i] = 1'b1;
  end

  assign mem_req = at_mem & ~blk;

  lsu_age_arb #(.N(N)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc   (alloc),
    .busy    (busy),
    .mem_req (mem_req),
    .res_req (at_res),
    .res_fire(res_valid && res_ready),
    .mem_gnt (mem_gnt),
    .res_oh  (res_oh),
    .older   (older)
  );

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    res_tag   = '0;
    res_data  = '0;
    for (int i = 0; i < N; i++) begin
      if (mem_gnt[i]) begin
        mem_addr  = mem_addr  | addr_a[i];
        mem_wdata = mem_wdata | wdat_a[i];
      end
      if (res_oh[i]) begin
        res_tag  = res_tag  | dst_a[i];
        res_data = res_data | rdat_a[i];
      end
    end
  end

  assign mem_valid = |mem_gnt;
  assign mem_we    = |mem_gnt[N-1:NUM_LD];
  assign res_valid = |at_res;
  assign res_take  = res_oh & {N{res_valid && res_ready}};

  // R5: a stalled result holds still until accepted
  a_r5_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_tag) && $stable(res_data)));
endmodule

// File: tb/tb_lsu_mem_unit.sv
module tb_lsu_mem_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic iss_valid = 0, iss_store = 0, iss_base_rdy = 0, iss_data_rdy = 0;
  logic [3:0] iss_dst = 0, iss_base_tag = 0, iss_data_tag = 0, cdb_tag = 0;
  logic [15:0] iss_base_val = 0, iss_data_val = 0, cdb_data = 0;
  logic [6:0] iss_off = 0;
  logic cdb_valid = 0, res_ready = 1;
  logic iss_ready, res_valid, mem_valid, mem_we;
  logic [3:0] res_tag;
  logic [15:0] res_data, mem_addr, mem_wdata, mem_rdata;

  lsu_mem_unit dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_store(iss_store), .iss_dst(iss_dst),
    .iss_base_tag(iss_base_tag), .iss_base_val(iss_base_val), .iss_base_rdy(iss_base_rdy),
    .iss_data_tag(iss_data_tag), .iss_data_val(iss_data_val), .iss_data_rdy(iss_data_rdy),
    .iss_off(iss_off), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  logic [15:0] bmem [256];
  assign mem_rdata = bmem[mem_addr[7:0]];

  int cyc = 0, mcnt = 0, rcnt = 0;
  logic        mwe  [64];
  logic [15:0] madr [64];
  logic [15:0] mdat [64];
  int          mcyc [64];
  logic [3:0]  rtg  [64];
  logic [15:0] rdt  [64];
  int          rcy  [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mcnt < 64) begin
      mwe[mcnt] <= mem_we; madr[mcnt] <= mem_addr;
      mdat[mcnt] <= mem_we ? mem_wdata : mem_rdata; mcyc[mcnt] <= cyc;
      mcnt <= mcnt + 1;
    end
    if (mem_valid && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (res_valid && res_ready && rcnt < 64) begin
      rtg[rcnt] <= res_tag; rdt[rcnt] <= res_data; rcy[rcnt] <= cyc;
      rcnt <= rcnt + 1;
    end
  end

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit st, input logic [3:0] dst, input logic [15:0] bval, input bit brdy,
                       input logic [3:0] btag, input logic [15:0] dval, input bit drdy,
                       input logic [3:0] dtag, input logic [6:0] off, output int k);
    @(negedge clk);
    iss_store = st; iss_dst = dst; iss_base_val = bval; iss_base_rdy = brdy; iss_base_tag = btag;
    iss_data_val = dval; iss_data_rdy = drdy; iss_data_tag = dtag; iss_off = off; iss_valid = 1;
    forever begin
      @(posedge clk);
      if (iss_ready) begin k = cyc; break; end
    end
    @(negedge clk);
    iss_valid = 0; iss_store = 0; cdb_valid = 0;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [15:0] d, output int c);
    @(negedge clk);
    cdb_valid = 1; cdb_tag = t; cdb_data = d;
    @(posedge clk);
    c = cyc;
    @(negedge clk);
    cdb_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 iss_ready after reset", int'(iss_ready), 1);
    check("R9 res_valid after reset", int'(res_valid), 0);
    check("R9 mem_valid after reset", int'(mem_valid), 0);
  endtask

  task automatic t_basic_load;
    int k, m0, r0;
    m0 = mcnt; r0 = rcnt;
    issue(0, 4'd5, 16'h0010, 1, 0, 0, 1, 0, 7'h10, k);
    idle(4);
    check("R4 one access", mcnt - m0, 1);
    check("R4 load access edge", mcyc[m0], k + 2);
    check("R2 load address", int'(madr[m0]), 16'h0020);
    check("R5 load is read", int'(mwe[m0]), 0);
    check("R5 result count", rcnt - r0, 1);
    check("R4 result edge", rcy[r0], k + 3);
    check("R5 result tag", int'(rtg[r0]), 5);
    check("R5 result data", int'(rdt[r0]), 16'hBEEF);
  endtask

  task automatic t_offsets;
    int k, m0, r0;
    m0 = mcnt; r0 = rcnt;
    issue(0, 4'd9, 16'h0010, 1, 0, 0, 1, 0, 7'h40, k);
    idle(4);
    check("R2 offset -64 address", int'(madr[m0]), 16'hFFD0);
    check("R2 offset -64 data", int'(rdt[r0]), 16'h10D0);
    issue(0, 4'd10, 16'hFFF0, 1, 0, 0, 1, 0, 7'h3F, k);
    idle(4);
    check("R2 offset 63 wrap address", int'(madr[m0 + 1]), 16'h002F);
    check("R2 offset 63 tag", int'(rtg[r0 + 1]), 10);
  endtask

  task automatic t_store;
    int k, m0, r0;
    m0 = mcnt; r0 = rcnt;
    issue(1, 4'd0, 16'h0030, 1, 0, 16'hCAFE, 1, 0, 7'h01, k);
    idle(4);
    check("R6 one access", mcnt - m0, 1);
    check("R6 is write", int'(mwe[m0]), 1);
    check("R6 address", int'(madr[m0]), 16'h0031);
    check("R6 data", int'(mdat[m0]), 16'hCAFE);
    check("R4 store access edge", mcyc[m0], k + 2);
    check("R6 no result transfer", rcnt - r0, 0);
  endtask

  task automatic t_operand_wait;
    int k, c, m0, r0;
    m0 = mcnt; r0 = rcnt;
    issue(0, 4'd6, 16'h0000, 0, 4'd7, 0, 1, 0, 7'h03, k);
    idle(4);
    check("R3 load waits for base", mcnt - m0, 0);
    bcast(4'd7, 16'h0040, c);
    idle(4);
    check("R3 load address from bus", int'(madr[m0]), 16'h0043);
    check("R4 access after bus edge", mcyc[m0], c + 2);
    check("R3 load data", int'(rdt[r0]), 16'h1043);
    issue(1, 4'd0, 16'h0080, 1, 0, 16'h0000, 0, 4'd9, 7'h00, k);
    idle(3);
    check("R3 store waits for data", mcnt - m0, 1);
    bcast(4'd9, 16'h5A5A, c);
    idle(4);
    check("R3 store data from bus", int'(mdat[m0 + 1]), 16'h5A5A);
    check("R4 store edge after bus", mcyc[m0 + 1], c + 2);
    // operand broadcast in the transfer cycle itself
    @(negedge clk);
    cdb_valid = 1; cdb_tag = 4'd3; cdb_data = 16'h0050;
    issue(0, 4'd11, 16'h0000, 0, 4'd3, 0, 1, 0, 7'h00, k);
    idle(4);
    check("R3 same-cycle capture address", int'(madr[m0 + 2]), 16'h0050);
    check("R3 same-cycle capture edge", mcyc[m0 + 2], k + 2);
  endtask

  task automatic t_backpressure;
    int k, m0, r0;
    m0 = mcnt; r0 = rcnt;
    @(negedge clk); res_ready = 0;
    issue(0, 4'd1, 16'h0021, 1, 0, 0, 1, 0, 7'h00, k);
    issue(0, 4'd2, 16'h0022, 1, 0, 0, 1, 0, 7'h00, k);
    idle(4);
    check("R5 stalled valid", int'(res_valid), 1);
    check("R5 stalled tag", int'(res_tag), 1);
    check("R5 stalled data", int'(res_data), 16'h1021);
    idle(3);
    check("R5 held tag", int'(res_tag), 1);
    check("R5 held data", int'(res_data), 16'h1021);
    iss_store = 0;
    @(negedge clk);
    check("R1 load slots full", int'(iss_ready), 0);
    iss_store = 1;
    @(negedge clk);
    check("R1 store slot free", int'(iss_ready), 1);
    iss_store = 0; res_ready = 1;
    idle(3);
    check("R5 two transfers", rcnt - r0, 2);
    check("R5 first tag", int'(rtg[r0]), 1);
    check("R5 second tag", int'(rtg[r0 + 1]), 2);
    check("R5 second data", int'(rdt[r0 + 1]), 16'h1022);
  endtask

  task automatic t_store_order;
    int k, c, m0, r0;
    m0 = mcnt; r0 = rcnt;
    issue(1, 4'd0, 16'h0050, 1, 0, 16'h0000, 0, 4'd10, 7'h00, k);
    issue(0, 4'd3, 16'h0050, 1, 0, 0, 1, 0, 7'h00, k);
    issue(0, 4'd4, 16'h0060, 1, 0, 0, 1, 0, 7'h00, k);
    idle(5);
    check("R7 loads held behind unresolved store", mcnt - m0, 0);
    bcast(4'd10, 16'h7777, c);
    idle(6);
    check("R8 store first", int'(mwe[m0]), 1);
    check("R8 store edge", mcyc[m0], c + 2);
    check("R7 aliasing load after store", int'(madr[m0 + 1]), 16'h0050);
    check("R8 older load next", mcyc[m0 + 1], c + 3);
    check("R8 younger load last", mcyc[m0 + 2], c + 4);
    check("R7 load sees stored word", int'(rdt[r0]), 16'h7777);
    check("R7 other load data", int'(rdt[r0 + 1]), 16'h1060);
  endtask

  task automatic t_load_older;
    int k, c, m0;
    m0 = mcnt;
    issue(0, 4'd8, 16'h0000, 0, 4'd12, 0, 1, 0, 7'h05, k);
    issue(1, 4'd0, 16'h0000, 0, 4'd12, 16'h3333, 1, 0, 7'h06, k);
    idle(3);
    bcast(4'd12, 16'h0070, c);
    idle(5);
    check("R8 older load wins", int'(mwe[m0]), 0);
    check("R8 load edge", mcyc[m0], c + 2);
    check("R8 store waits a cycle", mcyc[m0 + 1], c + 3);
    check("R2 store address", int'(madr[m0 + 1]), 16'h0076);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'h1000 + 16'(i);
    bmem[8'h20] = 16'hBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic_load();
    t_offsets();
    t_store();
    t_operand_wait();
    t_backpressure();
    t_store_order();
    t_load_older();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule